// File: doc/BRIEF.md
# Pipelined Burst Read Responder

This block sits on the memory side of a synchronous 64-bit bus and answers block reads of either four or sixteen 32-bit words. The master presents a word address and a size select. The cycle in which the request is taken counts as the address cycle. The responder then models the slow first access of the memory with a counter. It returns the words two per clock as 64-bit beats, with a valid flag and a marker on the final beat of the block.

A sixteen-word block is handled as four groups of four words. The fetch of each following group runs while the current group is on the bus and during the two idle cycles that follow it. The long first-access delay is therefore paid once per block, not once per group. Every group is followed by two idle bus cycles. A new request is held off until the last idle cycle of the previous block has passed.

The returned data is a fixed function of the word address, so every beat can be predicted. A free-running cycle counter measures each block from its address cycle to its final idle cycle and reports the total when the block completes.

Top module: `burst_rd_resp`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `busy` is 0, and `beat_valid` and `blk_done` are 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1, and that cycle is the address cycle. From the next cycle on, `req_ready` is 0 and `busy` is 1 until the block has finished.
- R3: The first beat of a block is presented exactly 41 cycles after the address cycle, which is 1 address cycle plus 40 cycles of access time.
- R4: Each four-word group appears as exactly 2 beats in consecutive cycles, followed by exactly 2 cycles with `beat_valid` at 0.
- R5: A four-word block (`req_long`=0) produces 2 beats, and `req_ready` returns 45 cycles after the address cycle.
- R6: A sixteen-word block (`req_long`=1) produces beats at offsets 41, 42, 45, 46, 49, 50, 53 and 54 after the address cycle, and `req_ready` returns at offset 57.
- R7: `beat_last` is 1 on the final beat of a block and on no other cycle.
- R8: Beats carry word addresses in ascending order, starting at `req_addr` and wrapping modulo 2^32. The word at address a is a XOR 32'h5A5AC3C3. The lower-addressed word of each beat is in bits 31:0 and the next word is in bits 63:32.
- R9: While a block is in progress, requests are held off and not dropped. A request that is held on the inputs is taken in the first cycle in which `req_ready` returns. Changing `req_addr` or `req_long` during a block has no effect on the data of that block.
- R10: `blk_done` pulses for one cycle, in the cycle in which `req_ready` returns. In that cycle `blk_cycles` gives the length of the block in cycles: 45 for a short block and 57 for a long one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Starting word address |
| req_long | input | 1 | 1 selects sixteen words, 0 selects four words |
| req_ready | output | 1 | Responder can take a request this cycle |
| busy | output | 1 | A block is in progress |
| beat_valid | output | 1 | A data beat is on `beat_data` |
| beat_data | output | 64 | Two words: lower address in bits 31:0 |
| beat_last | output | 1 | Final beat of the block |
| blk_done | output | 1 | One-cycle pulse when a block completes |
| blk_cycles | output | 16 | Length of the completed block in cycles |

## Verification
The bench checks every cycle of each block against the expected timeline. An off-by-one in the access counter moves the first beat away from offset 41. A group pipeline that waits for a full fetch after the idle cycles stretches the long block beyond 57 cycles and moves its later beats. A request is kept asserted through a whole block to show that it is held off and then taken in the very cycle in which ready returns; a responder that dropped it would never start the second block. The address inputs change during a block, and a start address near the top of the address space tests wrapping. A design that read its inputs late, or that set the last flag on every group, returns wrong words or flags an early beat.

// File: rtl/burst_rd_resp.sv
module burst_rd_resp #(
  parameter int WORD_W    = 32,
  parameter int FIRST_LAT = 40,
  parameter int NEXT_LAT  = 4,
  parameter int IDLE_CYC  = 2,
  parameter int LONG_GRPS = 4,
  parameter int CNT_W     = 16,
  parameter logic [WORD_W-1:0] PATTERN = 32'h5A5AC3C3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [WORD_W-1:0]   req_addr,
  input  logic                req_long,
  output logic                req_ready,
  output logic                busy,
  output logic                beat_valid,
  output logic [2*WORD_W-1:0] beat_data,
  output logic                beat_last,
  output logic                blk_done,
  output logic [CNT_W-1:0]    blk_cycles
);
  localparam int GRP_BEATS = 2;
  localparam int GRP_W = $clog2(LONG_GRPS + 1);
  localparam int LAT_W = $clog2(FIRST_LAT + NEXT_LAT + IDLE_CYC + 1);

  typedef enum logic [1:0] {S_RDY, S_WAIT, S_XFER, S_GAP} st_t;

  st_t               st;
  logic [LAT_W-1:0]  wcnt, fcnt;
  logic [GRP_W-1:0]  grp_left;
  logic              beat_idx;
  logic [WORD_W-1:0] waddr;
  logic [CNT_W-1:0]  cyc, t0, lat_q;
  logic              done_q, is_long;
  logic              accept;

  assign req_ready  = (st == S_RDY);
  assign busy       = ~req_ready;
  assign accept     = req_valid & req_ready;
  assign beat_valid = (st == S_XFER);
  assign beat_last  = beat_valid & beat_idx & (grp_left == GRP_W'(1));
  assign beat_data  = {(waddr + WORD_W'(1)) ^ PATTERN, waddr ^ PATTERN};
  assign blk_done   = done_q;
  assign blk_cycles = lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_RDY;
      wcnt     <= '0;
      fcnt     <= '0;
      grp_left <= '0;
      beat_idx <= 1'b0;
      waddr    <= '0;
      cyc      <= '0;
      t0       <= '0;
      lat_q    <= '0;
      done_q   <= 1'b0;
      is_long  <= 1'b0;
    end else begin
      cyc    <= cyc + CNT_W'(1);
      done_q <= 1'b0;
      if (fcnt != '0) fcnt <= fcnt - LAT_W'(1);
      case (st)
        S_RDY: if (accept) begin
          st       <= S_WAIT;
          wcnt     <= LAT_W'(FIRST_LAT - 1);
          waddr    <= req_addr;
          grp_left <= req_long ? GRP_W'(LONG_GRPS) : GRP_W'(1);
          is_long  <= req_long;
          t0       <= cyc;
        end
        S_WAIT: begin
          if (wcnt == '0) begin
            st       <= S_XFER;
            beat_idx <= 1'b0;
            fcnt     <= LAT_W'(NEXT_LAT);
          end else begin
            wcnt <= wcnt - LAT_W'(1);
          end
        end
        S_XFER: begin
          waddr <= waddr + WORD_W'(2);
          if (beat_idx) begin
            st       <= S_GAP;
            wcnt     <= LAT_W'(IDLE_CYC - 1);
            grp_left <= grp_left - GRP_W'(1);
          end else begin
            beat_idx <= 1'b1;
          end
        end
        S_GAP: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - LAT_W'(1);
          end else if (grp_left == '0) begin
            st     <= S_RDY;
            done_q <= 1'b1;
            lat_q  <= cyc - t0 + CNT_W'(1);
          end else if (fcnt <= LAT_W'(1)) begin
            st       <= S_XFER;
            beat_idx <= 1'b0;
            fcnt     <= LAT_W'(NEXT_LAT);
          end
        end
        default: st <= S_RDY;
      endcase
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  // R4
  pair_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) |=> !beat_valid);

  // R7
  last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  // R8
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) |->
      (beat_data[WORD_W-1:0] ^ PATTERN) == (($past(beat_data[WORD_W-1:0]) ^ PATTERN) + WORD_W'(2)));

  // R10
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> blk_cycles == CNT_W'(1 + FIRST_LAT + (is_long ? LONG_GRPS : 1) * (GRP_BEATS + IDLE_CYC)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> req_ready ##1 !blk_done);
endmodule

// File: tb/sim_burst_rd_resp.sv
module sim_burst_rd_resp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_long = 1'b0;
  logic        req_ready, busy, beat_valid, beat_last, blk_done;
  logic [63:0] beat_data;
  logic [15:0] blk_cycles;

  int checks = 0;
  int errors = 0;
  localparam logic [31:0] PAT = 32'h5A5AC3C3;

  always #5 clk = ~clk;

  burst_rd_resp u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_long(req_long), .req_ready(req_ready), .busy(busy),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_last(beat_last),
    .blk_done(blk_done), .blk_cycles(blk_cycles)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one block. If pre is set, the request is already on the inputs.
  // If chain is set, a next request (naddr/nlong) is raised during the block and left pending.
  task automatic run_block(input logic [31:0] addr, input logic lng, input logic pre,
                           input logic chain, input logic [31:0] naddr, input logic nlong);
    int total = lng ? 57 : 45;
    int grps = lng ? 4 : 1;
    if (!pre) begin
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = addr; req_long = lng;
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
    req_addr = ~addr; req_long = ~lng; // R9: changes during the block must not matter
    @(negedge clk);
    for (int off = 1; off <= total; off++) begin
      int rel = off - 41;
      logic ev = (off >= 41) && ((rel % 4) < 2) && ((rel / 4) < grps);
      logic el = ev && ((rel / 4) == grps - 1) && ((rel % 4) == 1);
      if (chain && off == 5) begin
        req_valid = 1'b1; req_addr = naddr; req_long = nlong;
      end
      if (off == 41) chk(beat_valid === 1'b1, "R3 first beat", {63'd0, beat_valid}, 64'd1);
      chk(beat_valid === ev, lng ? "R6/R4 beat timing" : "R5/R4 beat timing", {63'd0, beat_valid}, {63'd0, ev});
      chk(beat_last === el, "R7 last flag", {63'd0, beat_last}, {63'd0, el});
      if (ev) begin
        logic [31:0] w = addr + 32'(((rel / 4) * 4) + (rel % 4) * 2);
        logic [63:0] ed = {(w + 32'd1) ^ PAT, w ^ PAT};
        chk(beat_data === ed, "R8 beat data", beat_data, ed);
      end
      if (off == total) begin
        chk(req_ready === 1'b1, lng ? "R6 ready return" : "R5 ready return", {63'd0, req_ready}, 64'd1);
        chk(blk_done === 1'b1, "R10 done pulse", {63'd0, blk_done}, 64'd1);
        chk(blk_cycles === 16'(total), "R10 block length", {48'd0, blk_cycles}, 64'(total));
      end else begin
        chk(req_ready === 1'b0 && busy === 1'b1, "R2/R9 held off while busy", {62'd0, req_ready, busy}, 64'd1);
        chk(blk_done === 1'b0, "R10 no early done", {63'd0, blk_done}, 64'd0);
      end
      if (off != total) @(negedge clk);
    end
    if (!chain) begin
      @(negedge clk);
      chk(blk_done === 1'b0, "R10 done is one cycle", {63'd0, blk_done}, 64'd0);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0, "R1 reset ready", {62'd0, req_ready, busy}, 64'd2);
    chk(beat_valid === 1'b0 && blk_done === 1'b0, "R1 reset quiet", {62'd0, beat_valid, blk_done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0, "R1 ready after reset", {62'd0, req_ready, busy}, 64'd2);
    chk(beat_valid === 1'b0, "R1 no beat after reset", {63'd0, beat_valid}, 64'd0);
  endtask

  task automatic test_short();
    run_block(32'd100, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic test_long();
    run_block(32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic test_held_chain();
    run_block(32'h0000_0040, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFF8, 1'b1);
    run_block(32'hFFFF_FFF8, 1'b1, 1'b1, 1'b1, 32'h0000_0777, 1'b0);
    run_block(32'h0000_0777, 1'b0, 1'b1, 1'b0, 32'd0, 1'b0);
  endtask

  initial begin
    test_reset();
    test_short();
    test_long();
    test_held_chain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule